// File: doc/BRIEF.md
# Half-Cycle Selective PWM Gate Generator

This block drives the six gates of a single-stage boost inverter made of two bidirectional boost legs (leg A and leg B, each with a low and a high switch) plus one line-frequency clamp switch per output side. A signed reference sample picks the half line cycle. Only the leg that belongs to that half is pulse-width modulated, as a complementary low/high pair with programmable dead time. The other leg is held static. Either its high switch conducts (open mode), or both of its switches are off and the clamp on its side conducts (clamped mode). As a result, only two of the six devices switch at carrier frequency at any time.

A free-running up-counter of programmable period forms the carrier. The duty word, the period, the dead time, the half-cycle selection and the mode are all captured together at each carrier period boundary. The duty word is computed upstream: it is the boost-law value for the active leg, already scaled to carrier counts. When the captured half or mode differs from the one in force, the next period becomes a changeover period. It opens with a dead-time interval in which every gate is off, so every static switch and clamp changes only behind that interval.

Top module: `hcp_gate_gen`

## Requirements
- R1: A synchronous active-high reset drives all six gate outputs low. After release, the outputs stay all low for exactly `dead_time` cycles before the first gate turns on.
- R2: The carrier period is `period` clock cycles. The active leg's low switch is on for the first D counts of each period, where D is the duty word captured at the start of that period. A duty of zero keeps the low switch off for the whole period.
- R3: A captured duty greater than `period` − 2·`dead_time` is saturated to `period` − 2·`dead_time`.
- R4: Within a period, the active leg's high switch is on for `period` − 2·`dead_time` − D cycles. Each transition between the low and high switch of that leg is separated by exactly `dead_time` cycles with both switches off, and the two are never on together.
- R5: When the sign bit of `ref_sample` is 0 (zero or positive), leg A is modulated. When it is 1, leg B is modulated.
- R6: In open mode (`clamp_mode` = 0), the idle leg's high switch is held on, its low switch is held off, and both clamps are off.
- R7: In clamped mode (`clamp_mode` = 1), both switches of the idle leg are held off. The clamp on the idle side is held on: `clamp_b` while leg A is active and `clamp_a` while leg B is active. The other clamp is off.
- R8: A change of reference sign or of mode takes effect only at the next carrier period boundary. The pattern in force runs to the end of its period.
- R9: In the first period after a change of half or mode, all six gates are off for the first `dead_time` cycles. The new active low switch stays off for that period. Clamps therefore change state only at these boundaries, each time behind an all-off interval.
- R10: The low switches of the two legs are never on at the same time. The two clamps are never on at the same time.
- Operating range: `dead_time` ≥ 1 and `period` ≥ 2·`dead_time` + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clamp_mode | input | 1 | 0 = open mode, 1 = clamped mode |
| ref_sample | input | REF_W | Signed reference; its sign selects the half cycle |
| duty | input | CNT_W | Low-switch on-time in carrier counts |
| period | input | CNT_W | Carrier period in clock cycles |
| dead_time | input | DT_W | Dead-time length in clock cycles |
| leg_a_lo | output | 1 | Leg A low switch gate |
| leg_a_hi | output | 1 | Leg A high switch gate |
| leg_b_lo | output | 1 | Leg B low switch gate |
| leg_b_hi | output | 1 | Leg B high switch gate |
| clamp_a | output | 1 | Side A clamp gate |
| clamp_b | output | 1 | Side B clamp gate |

## Verification
Some rules are checked by the assertions on every cycle:
- the two switches of a pair never overlap;
- at least one off cycle separates the two switches of a pair;
- only one low switch is active at a time;
- the clamps are exclusive and never conduct beside their own leg;
- every clamp edge sits next to an all-off cycle;
- the outputs are quiet during reset.

Other behaviour needs known settings, so only the bench scenarios can show it:
- the exact dead-time length on each edge;
- the on-times that follow from the duty word and from its saturation;
- which leg is active for a given sign;
- that a sign change waits for the period boundary;
- the length of the all-off changeover window.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

  typedef enum logic {
    HALF_POS = 1'b0,
    HALF_NEG = 1'b1
  } half_e;

  typedef struct packed {
    logic a_lo;
    logic a_hi;
    logic b_lo;
    logic b_hi;
    logic cl_a;
    logic cl_b;
  } gate_t;

endpackage

// File: rtl/hcp_carrier.sv
module hcp_carrier
  import hcp_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DT_W  = 6,
  parameter int REF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clamp_mode,
  input  logic signed [REF_W-1:0] ref_sample,
  input  logic [CNT_W-1:0]        duty,
  input  logic [CNT_W-1:0]        period,
  input  logic [DT_W-1:0]         dead_time,
  output logic [CNT_W-1:0]        cnt_q,
  output logic [CNT_W-1:0]        per_q,
  output logic [DT_W-1:0]         dt_q,
  output logic [CNT_W-1:0]        duty_q,
  output half_e                   half_q,
  output logic                    clamp_q,
  output logic                    trans_q
);

  localparam int EW = CNT_W + 1;

  logic          wrap;
  logic [EW-1:0] limit;
  logic [EW-1:0] duty_sat;
  half_e         half_d;
  logic          changed;

  // Boundary: the last count of the captured period.
  assign wrap = (EW'(cnt_q) + EW'(1)) >= EW'(per_q);

  // Largest duty that still leaves room for both dead-time gaps.
  assign limit    = EW'(period) - (EW'(dead_time) << 1);
  assign duty_sat = (EW'(duty) > limit) ? limit : EW'(duty);

  assign half_d  = (ref_sample < 0) ? HALF_NEG : HALF_POS;
  assign changed = (half_d != half_q) || (clamp_mode != clamp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      per_q   <= period;
      dt_q    <= dead_time;
      duty_q  <= '0;
      half_q  <= half_d;
      clamp_q <= clamp_mode;
      trans_q <= 1'b1;
    end else if (wrap) begin
      cnt_q   <= '0;
      per_q   <= period;
      dt_q    <= dead_time;
      duty_q  <= changed ? '0 : duty_sat[CNT_W-1:0];
      half_q  <= half_d;
      clamp_q <= clamp_mode;
      trans_q <= changed;
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/hcp_phase.sv
module hcp_phase #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 6
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per,
  input  logic [DT_W-1:0]  dt,
  input  logic [CNT_W-1:0] duty,
  output logic             lo_ph,
  output logic             hi_ph,
  output logic             blank_win
);

  localparam int EW = CNT_W + 1;

  logic [EW-1:0] c_e;
  logic [EW-1:0] hi_start;
  logic [EW-1:0] hi_end;

  assign c_e      = EW'(cnt);
  assign hi_start = EW'(duty) + EW'(dt);
  assign hi_end   = EW'(per) - EW'(dt);

  // Phase 1: low on. Phase 2: gap. Phase 3: high on. Phase 4: gap.
  assign lo_ph     = c_e < EW'(duty);
  assign hi_ph     = (c_e >= hi_start) && (c_e < hi_end);
  assign blank_win = c_e < EW'(dt);

endmodule

// File: rtl/hcp_steer.sv
module hcp_steer
  import hcp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  half_e half,
  input  logic  clamp,
  input  logic  trans,
  input  logic  blank_win,
  input  logic  lo_ph,
  input  logic  hi_ph,
  output gate_t gate_q
);

  localparam int LEGS = 2;

  logic             blank;
  logic [LEGS-1:0]  lo_n;
  logic [LEGS-1:0]  hi_n;
  logic [LEGS-1:0]  cl_n;
  gate_t            gate_d;

  assign blank = trans && blank_win;

  for (genvar i = 0; i < LEGS; i++) begin : g_leg
    localparam half_e LEG_HALF = (i == 0) ? HALF_POS : HALF_NEG;
    logic active;
    assign active  = (half == LEG_HALF);
    assign lo_n[i] = active && lo_ph;
    assign hi_n[i] = active ? hi_ph : (!clamp && !blank);
    assign cl_n[i] = !active && clamp && !blank;
  end

  always_comb begin
    gate_d      = '0;
    gate_d.a_lo = lo_n[0];
    gate_d.a_hi = hi_n[0];
    gate_d.b_lo = lo_n[1];
    gate_d.b_hi = hi_n[1];
    gate_d.cl_a = cl_n[0];
    gate_d.cl_b = cl_n[1];
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= '0;
    else     gate_q <= gate_d;
  end

endmodule

// File: rtl/hcp_gate_gen.sv
module hcp_gate_gen
  import hcp_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DT_W  = 6,
  parameter int REF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clamp_mode,
  input  logic signed [REF_W-1:0] ref_sample,
  input  logic [CNT_W-1:0]        duty,
  input  logic [CNT_W-1:0]        period,
  input  logic [DT_W-1:0]         dead_time,
  output logic                    leg_a_lo,
  output logic                    leg_a_hi,
  output logic                    leg_b_lo,
  output logic                    leg_b_hi,
  output logic                    clamp_a,
  output logic                    clamp_b
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic [DT_W-1:0]  dt_q;
  logic [CNT_W-1:0] duty_q;
  half_e            half_q;
  logic             clamp_q;
  logic             trans_q;
  logic             lo_ph;
  logic             hi_ph;
  logic             blank_win;
  gate_t            gate_q;

  hcp_carrier #(.CNT_W(CNT_W), .DT_W(DT_W), .REF_W(REF_W)) u_carrier (
    .clk        (clk),
    .rst        (rst),
    .clamp_mode (clamp_mode),
    .ref_sample (ref_sample),
    .duty       (duty),
    .period     (period),
    .dead_time  (dead_time),
    .cnt_q      (cnt_q),
    .per_q      (per_q),
    .dt_q       (dt_q),
    .duty_q     (duty_q),
    .half_q     (half_q),
    .clamp_q    (clamp_q),
    .trans_q    (trans_q)
  );

  hcp_phase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_phase (
    .cnt       (cnt_q),
    .per       (per_q),
    .dt        (dt_q),
    .duty      (duty_q),
    .lo_ph     (lo_ph),
    .hi_ph     (hi_ph),
    .blank_win (blank_win)
  );

  hcp_steer u_steer (
    .clk       (clk),
    .rst       (rst),
    .half      (half_q),
    .clamp     (clamp_q),
    .trans     (trans_q),
    .blank_win (blank_win),
    .lo_ph     (lo_ph),
    .hi_ph     (hi_ph),
    .gate_q    (gate_q)
  );

  assign leg_a_lo = gate_q.a_lo;
  assign leg_a_hi = gate_q.a_hi;
  assign leg_b_lo = gate_q.b_lo;
  assign leg_b_hi = gate_q.b_hi;
  assign clamp_a  = gate_q.cl_a;
  assign clamp_b  = gate_q.cl_b;

endmodule

// File: rtl/hcp_checker.sv
module hcp_checker (
  input logic clk,
  input logic rst,
  input logic leg_a_lo,
  input logic leg_a_hi,
  input logic leg_b_lo,
  input logic leg_b_hi,
  input logic clamp_a,
  input logic clamp_b
);

  logic legs_off;
  assign legs_off = !leg_a_lo && !leg_a_hi && !leg_b_lo && !leg_b_hi;

  assert_rst_quiet_R1: assert property (@(posedge clk)
    rst |=> (!leg_a_lo && !leg_a_hi && !leg_b_lo && !leg_b_hi && !clamp_a && !clamp_b));

  assert_pair_a_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(leg_a_lo && leg_a_hi));

  assert_pair_b_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(leg_b_lo && leg_b_hi));

  assert_gap_a_hi_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(leg_a_hi) |-> !$past(leg_a_lo));

  assert_gap_a_lo_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(leg_a_lo) |-> !$past(leg_a_hi));

  assert_gap_b_hi_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(leg_b_hi) |-> !$past(leg_b_lo));

  assert_gap_b_lo_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(leg_b_lo) |-> !$past(leg_b_hi));

  assert_one_leg_pwm_R10: assert property (@(posedge clk) disable iff (rst)
    !(leg_a_lo && leg_b_lo));

  assert_clamp_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clamp_a, clamp_b}));

  assert_clamp_a_side_R7: assert property (@(posedge clk) disable iff (rst)
    clamp_a |-> (!leg_a_lo && !leg_a_hi));

  assert_clamp_b_side_R7: assert property (@(posedge clk) disable iff (rst)
    clamp_b |-> (!leg_b_lo && !leg_b_hi));

  assert_clamp_on_blank_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(clamp_a) || $rose(clamp_b)) |-> $past(legs_off && !clamp_a && !clamp_b));

  assert_clamp_off_blank_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(clamp_a) || $fell(clamp_b)) |-> $past(legs_off));

endmodule

bind hcp_gate_gen hcp_checker u_hcp_checker (
  .clk      (clk),
  .rst      (rst),
  .leg_a_lo (leg_a_lo),
  .leg_a_hi (leg_a_hi),
  .leg_b_lo (leg_b_lo),
  .leg_b_hi (leg_b_hi),
  .clamp_a  (clamp_a),
  .clamp_b  (clamp_b)
);

// File: tb/tb_hcp_gate_gen.sv
module tb_hcp_gate_gen;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int DT_W  = 4;
  localparam int REF_W = 8;

  logic                    clk = 1'b0;
  logic                    rst;
  logic                    clamp_mode;
  logic signed [REF_W-1:0] ref_sample;
  logic [CNT_W-1:0]        duty;
  logic [CNT_W-1:0]        period;
  logic [DT_W-1:0]         dead_time;
  logic leg_a_lo, leg_a_hi, leg_b_lo, leg_b_hi, clamp_a, clamp_b;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcp_gate_gen #(.CNT_W(CNT_W), .DT_W(DT_W), .REF_W(REF_W)) dut (
    .clk(clk), .rst(rst), .clamp_mode(clamp_mode), .ref_sample(ref_sample),
    .duty(duty), .period(period), .dead_time(dead_time),
    .leg_a_lo(leg_a_lo), .leg_a_hi(leg_a_hi), .leg_b_lo(leg_b_lo),
    .leg_b_hi(leg_b_hi), .clamp_a(clamp_a), .clamp_b(clamp_b));

  function automatic bit all_low();
    return !(leg_a_lo || leg_a_hi || leg_b_lo || leg_b_hi || clamp_a || clamp_b);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_in(input int p, input int t, input int d, input bit neg, input bit cm);
    @(negedge clk);
    period     = CNT_W'(p);
    dead_time  = DT_W'(t);
    duty       = CNT_W'(d);
    ref_sample = neg ? -8'sd40 : 8'sd40;
    clamp_mode = cm;
  endtask

  // Steady-state window of two periods; counts and gaps against the requirements.
  task automatic measure(input int p, input int t, input int d, input bit neg, input bit cm);
    int ds, n_alo, n_ahi, n_blo, n_bhi, n_ca, n_cb;
    int act_lo, act_hi, idl_lo, idl_hi, cl_idl, cl_oth;
    int last_on, off_run, gap_bad, alts;
    set_in(p, t, d, neg, cm);
    repeat (3*p) @(negedge clk);
    ds = (d > p - 2*t) ? p - 2*t : d;
    n_alo = 0; n_ahi = 0; n_blo = 0; n_bhi = 0; n_ca = 0; n_cb = 0;
    last_on = 0; off_run = 0; gap_bad = 0; alts = 0;
    for (int k = 0; k < 2*p; k++) begin
      logic lo_s, hi_s;
      n_alo += int'(leg_a_lo); n_ahi += int'(leg_a_hi);
      n_blo += int'(leg_b_lo); n_bhi += int'(leg_b_hi);
      n_ca  += int'(clamp_a);  n_cb  += int'(clamp_b);
      lo_s = neg ? leg_b_lo : leg_a_lo;
      hi_s = neg ? leg_b_hi : leg_a_hi;
      if (lo_s || hi_s) begin
        int now_on;
        now_on = lo_s ? 1 : 2;
        if (last_on != 0 && off_run > 0 && now_on != last_on) begin
          alts++;
          if (off_run != t) gap_bad++;
        end
        last_on = now_on;
        off_run = 0;
      end else begin
        off_run++;
      end
      @(negedge clk);
    end
    act_lo = neg ? n_blo : n_alo;  act_hi = neg ? n_bhi : n_ahi;
    idl_lo = neg ? n_alo : n_blo;  idl_hi = neg ? n_ahi : n_bhi;
    cl_idl = neg ? n_ca  : n_cb;   cl_oth = neg ? n_cb  : n_ca;
    // R2 R3: low on-time with saturation; R5 picks the leg by sign.
    check(act_lo == 2*ds, "R2/R3/R5 active low on-time", act_lo, 2*ds);
    // R4: high on-time fills the rest minus two gaps.
    check(act_hi == 2*(p-2*t-ds), "R4 active high on-time", act_hi, 2*(p-2*t-ds));
    check(gap_bad == 0, "R4 dead-time gap length", gap_bad, 0);
    if (ds >= 1 && ds <= p-2*t-1)
      check(alts >= 3, "R4 pair alternations", alts, 3);
    // R10: idle leg low switch never switches.
    check(idl_lo == 0, "R10 idle low switch", idl_lo, 0);
    // R6 / R7: static leg and clamps.
    check(idl_hi == (cm ? 0 : 2*p), cm ? "R7 idle high held off" : "R6 idle high held on",
          idl_hi, cm ? 0 : 2*p);
    check(cl_idl == (cm ? 2*p : 0), cm ? "R7 idle-side clamp on" : "R6 clamp off",
          cl_idl, cm ? 2*p : 0);
    check(cl_oth == 0, "R7 other clamp off", cl_oth, 0);
  endtask

  initial begin
    rst = 1'b1; clamp_mode = 1'b0; ref_sample = 8'sd40;
    duty = 8'd3; period = 8'd12; dead_time = 4'd2;
    repeat (3) @(negedge clk);
    // R1: quiet during reset.
    check(all_low(), "R1 outputs low in reset", 0, 0);
    rst = 1'b0;
    begin
      int z;
      z = 0;
      @(negedge clk);
      while (all_low() && z < 100) begin z++; @(negedge clk); end
      // R1 R9: first gate waits exactly one dead time after release.
      check(z == 2, "R1/R9 all-low run after reset", z, 2);
    end

    // Exhaustive duty sweeps for each half and mode, P=12 T=2.
    for (int m = 0; m < 4; m++)
      for (int d = 0; d <= 14; d++)
        measure(12, 2, d, m[0], m[1]);
    // Second configuration, P=15 T=3, leg A open and leg B clamped.
    for (int d = 0; d <= 17; d++) measure(15, 3, d, 1'b0, 1'b0);
    for (int d = 0; d <= 17; d++) measure(15, 3, d, 1'b1, 1'b1);

    // R5: zero reference counts as the positive half (leg A active).
    set_in(12, 2, 4, 1'b0, 1'b0);
    ref_sample = 8'sd0;
    repeat (36) @(negedge clk);
    begin
      int na;
      na = 0;
      for (int k = 0; k < 12; k++) begin na += int'(leg_a_lo); @(negedge clk); end
      check(na == 4, "R5 zero reference drives leg A", na, 4);
    end

    // R8 R9: sign flip right at a low-switch rising edge waits for the boundary.
    measure(12, 2, 3, 1'b0, 1'b0);
    begin
      int w, nb, nz;
      w = 0;
      while (!leg_a_lo && w < 50) begin w++; @(negedge clk); end
      ref_sample = -8'sd40;
      nb = 0;
      while (leg_b_hi && nb < 50) begin nb++; @(negedge clk); end
      check(nb == 12, "R8 old pattern holds to period end", nb, 12);
      nz = 0;
      while (all_low() && nz < 50) begin nz++; @(negedge clk); end
      check(nz == 2, "R9 all-off changeover window", nz, 2);
      check(leg_b_hi && leg_a_hi && !leg_b_lo, "R9 changeover period low suppressed",
            int'({leg_a_hi, leg_b_hi, leg_b_lo}), 3'b110);
    end

    // R9: mode change in clamped negative half, counted over a wide window.
    measure(12, 2, 5, 1'b1, 1'b1);
    begin
      int nz, nca, ncb;
      clamp_mode = 1'b0;
      nz = 0; nca = 0; ncb = 0;
      for (int k = 0; k < 48; k++) begin
        nz += int'(all_low());
        nca += int'(clamp_a); ncb += int'(clamp_b);
        @(negedge clk);
      end
      check(nz == 2, "R9 all-off cycles across mode change", nz, 2);
      check(ncb == 0, "R10 clamp_b stays off", ncb, 0);
      check(nca < 12, "R8 clamp_a released at boundary", nca, 11);
    end

    // R1: reset mid-run clears all gates.
    rst = 1'b1;
    @(negedge clk);
    check(all_low(), "R1 reset clears gates", 0, 0);
    rst = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule